// File: doc/BRIEF.md
# Glitch-Free Clock Halt and Power-Down Controller

This block gates three clocks for a board-level clock generator: a fast processor clock, a slower peripheral-bus clock and a reference clock. Three active-low controls decide what runs. A processor-halt input parks the processor clock. A bus-halt input parks the bus clock. A power-down input overrides both halts. It parks both gated clocks, cuts the reference clock, and drops the crystal-oscillator enable and one enable per frequency synthesizer. All three controls are resynchronised to the free-running bus clock before they are used.

The processor and bus outputs start and stop only on whole cycles and rest low while stopped. Each gate holds an enable that is captured on the falling edge of its own source clock and ANDed with that clock, so every pulse that leaves the block has a full high phase. When power-down is released, the oscillator and synthesizer enables return at once. A counter of `WAKE_CYCLES` bus-clock cycles must then expire before the gated clocks resume. The default count is about 3 ms at a 33.3 MHz bus clock.

The processor clock is assumed to be an integer multiple of the bus clock, derived from the same source, with its rising edges aligned to the bus clock's rising edges.

Top module: `clk_halt_ctrl`

## Requirements
- R1: After synchronous reset with all three controls high (inactive), the processor, bus and reference outputs toggle, `xtal_en` is 1 and every bit of `synth_en` is 1.
- R2: While `pwr_down_n` is 0, whatever the halt inputs are, the processor and bus outputs stay low, the reference output stops, and `xtal_en` and all `synth_en` bits are 0.
- R3: With `pwr_down_n` at 1, `proc_halt_n` at 0 parks the processor output low and leaves the bus output running.
- R4: With `pwr_down_n` at 1, `pbus_halt_n` at 0 parks the bus output low and leaves the processor output running.
- R5: With `pwr_down_n` at 1, the reference output runs and `xtal_en` and `synth_en` are 1 for all four combinations of the halt inputs.
- R6: Every high pulse on the processor or bus output lasts exactly half a period of its source clock, and no low phase is shorter than half a period. This holds through halts, restarts, power-down entry and power-down exit.
- R7: Turn-off latency. When a halt or power-down input falls between bus-clock edges, the last rising edge of the affected gated output comes no later than the 2nd bus-clock rising edge after the change.
- R8: Turn-on latency. When a halt input rises between bus-clock edges, the first gated rising edge comes no later than the 3rd bus-clock rising edge after the change. Two of those edges are the synchronizer and one is the gate.
- R9: After `pwr_down_n` rises, the oscillator and synthesizer enables return within 3 bus edges. No processor or bus pulse appears for at least `WAKE_CYCLES` bus periods, and the pulses resume within `WAKE_CYCLES`+5 bus periods.
- R10: If `pwr_down_n` falls again before the wake-up count expires, the block goes back to power-down. No gated pulse appears, and the enables drop again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pbus | input | 1 | Free-running bus clock. It clocks the control logic and is the gated bus source. |
| clk_proc | input | 1 | Free-running processor clock, edge-aligned integer multiple of `clk_pbus` |
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset, in the `clk_pbus` domain |
| proc_halt_n | input | 1 | Active-low processor clock halt |
| pbus_halt_n | input | 1 | Active-low bus clock halt |
| pwr_down_n | input | 1 | Active-low power-down, overrides both halts |
| proc_clk_gated | output | 1 | Gated processor clock, parked low |
| pbus_clk_gated | output | 1 | Gated bus clock, parked low |
| ref_clk_gated | output | 1 | Reference clock, cut during power-down |
| xtal_en | output | 1 | Crystal oscillator enable |
| synth_en | output | NUM_SYNTH | Per-synthesizer enable |

## Verification
The bench times every processor and bus pulse and every low phase against the source half period. A gate that switched its enable while the clock was high would show up as a short or stretched pulse. Latency is measured in wall time from a control change made at a bus-clock falling edge. A stop that arrived late would fail the turn-off bound, and a missing or extra synchronizer stage would fail the turn-on bound. The power-down tests check both ends of the wake-up window and release power-down early to catch a counter that keeps running through a re-entry. The table tests show the halts acting independently and the reference and enables surviving every halt combination.

// File: rtl/clkhalt_pkg.sv
package clkhalt_pkg;

  // Gated domains: index 0 processor, index 1 bus
  localparam int NUM_DOM = 2;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_WAKE = 2'd2
  } seq_state_t;

endpackage

// File: rtl/clkhalt_sync.sv
module clkhalt_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  // Active-low controls reset to their inactive (high) level
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/clkhalt_seq.sv
module clkhalt_seq
  import clkhalt_pkg::*;
#(
  parameter int WAKE_CYCLES = 100000,
  parameter int NUM_SYNTH   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwr_ok,
  input  logic [NUM_DOM-1:0]   halt_ok,
  output logic [NUM_DOM-1:0]   dom_req,
  output logic                 xtal_en,
  output logic [NUM_SYNTH-1:0] synth_en,
  output seq_state_t           state_o
);

  localparam int CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

  seq_state_t    state;
  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      wake_cnt <= '0;
    end else begin
      unique case (state)
        ST_RUN:  if (!pwr_ok) state <= ST_DOWN;
        ST_DOWN: if (pwr_ok) begin
                   state    <= ST_WAKE;
                   wake_cnt <= '0;
                 end
        ST_WAKE: if (!pwr_ok)                  state    <= ST_DOWN;
                 else if (wake_cnt == WAKE_LAST) state    <= ST_RUN;
                 else                           wake_cnt <= wake_cnt + 1'b1;
        default: state <= ST_DOWN;
      endcase
    end
  end

  // Oscillator and synthesizer enables follow the synchronized power control
  always_ff @(posedge clk) begin
    if (rst) xtal_en <= 1'b1;
    else     xtal_en <= pwr_ok;
  end

  for (genvar s = 0; s < NUM_SYNTH; s++) begin : g_synth
    always_ff @(posedge clk) begin
      if (rst) synth_en[s] <= 1'b1;
      else     synth_en[s] <= pwr_ok;
    end
  end

  // Power-down acts on the synchronized level at once, not one state later
  always_comb begin
    dom_req = '0;
    if (state == ST_RUN && pwr_ok) dom_req = halt_ok;
  end

  assign state_o = state;

endmodule

// File: rtl/clkhalt_gate.sv
module clkhalt_gate (
  input  logic clk,
  input  logic req,
  output logic en,
  output logic clk_g
);

  // Enable moves only while the clock is low, so each pulse is a full high phase
  always_ff @(negedge clk) begin
    en <= req;
  end

  assign clk_g = clk & en;

endmodule

// File: rtl/clk_halt_ctrl.sv
module clk_halt_ctrl
  import clkhalt_pkg::*;
#(
  parameter int WAKE_CYCLES = 100000,
  parameter int NUM_SYNTH   = 2
) (
  input  logic                 clk_pbus,
  input  logic                 clk_proc,
  input  logic                 clk_ref,
  input  logic                 rst,
  input  logic                 proc_halt_n,
  input  logic                 pbus_halt_n,
  input  logic                 pwr_down_n,
  output logic                 proc_clk_gated,
  output logic                 pbus_clk_gated,
  output logic                 ref_clk_gated,
  output logic                 xtal_en,
  output logic [NUM_SYNTH-1:0] synth_en
);

  localparam int NCTL = NUM_DOM + 1;

  logic [NCTL-1:0]    ctl_raw;
  logic [NCTL-1:0]    ctl_s;
  logic [NUM_DOM-1:0] dom_req;
  logic [NUM_DOM-1:0] gate_en;
  logic [NUM_DOM-1:0] src_clk;
  logic [NUM_DOM-1:0] gated;
  seq_state_t         seq_state;

  assign ctl_raw = {pwr_down_n, pbus_halt_n, proc_halt_n};

  clkhalt_sync #(.WIDTH(NCTL)) u_sync (
    .clk (clk_pbus),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  clkhalt_seq #(
    .WAKE_CYCLES (WAKE_CYCLES),
    .NUM_SYNTH   (NUM_SYNTH)
  ) u_seq (
    .clk      (clk_pbus),
    .rst      (rst),
    .pwr_ok   (ctl_s[NCTL-1]),
    .halt_ok  (ctl_s[NUM_DOM-1:0]),
    .dom_req  (dom_req),
    .xtal_en  (xtal_en),
    .synth_en (synth_en),
    .state_o  (seq_state)
  );

  assign src_clk = {clk_pbus, clk_proc};

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    clkhalt_gate u_gate (
      .clk   (src_clk[g]),
      .req   (dom_req[g]),
      .en    (gate_en[g]),
      .clk_g (gated[g])
    );
  end

  assign proc_clk_gated = gated[0];
  assign pbus_clk_gated = gated[1];

  // Reference is cut with no cycle alignment
  assign ref_clk_gated = clk_ref & xtal_en;

endmodule

// File: rtl/clkhalt_checker.sv
module clkhalt_checker
  import clkhalt_pkg::*;
#(
  parameter int NUM_SYNTH = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 proc_halt_n,
  input logic                 pbus_halt_n,
  input logic                 pwr_down_n,
  input logic                 xtal_en,
  input logic [NUM_SYNTH-1:0] synth_en,
  input logic [NUM_DOM-1:0]   gate_en,
  input seq_state_t           seq_state
);

  logic [2:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)           cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 1'b1;
  end

  // R2: sustained power-down drops oscillator and synthesizer enables
  a_r2_pd_enables_off: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && !pwr_down_n && !$past(pwr_down_n) && !$past(pwr_down_n, 2)
     && !$past(pwr_down_n, 3)) |-> (!xtal_en && (synth_en == '0)));

  // R2: with the oscillator off no gate is enabled
  a_r2_gates_off_in_down: assert property (@(posedge clk) disable iff (rst)
    !xtal_en |-> (gate_en == '0));

  // R3: sustained processor halt parks the processor gate
  a_r3_proc_parked: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd3 && !proc_halt_n && !$past(proc_halt_n) && !$past(proc_halt_n, 2))
    |-> !gate_en[0]);

  // R4: sustained bus halt parks the bus gate
  a_r4_pbus_parked: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd3 && !pbus_halt_n && !$past(pbus_halt_n) && !$past(pbus_halt_n, 2))
    |-> !gate_en[1]);

  // R5: sustained power-up keeps enables on
  a_r5_enables_on: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && pwr_down_n && $past(pwr_down_n) && $past(pwr_down_n, 2)
     && $past(pwr_down_n, 3)) |-> (xtal_en && (synth_en == '1)));

  // R8: an unhalted domain in the run state is enabled
  a_r8_proc_turn_on: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd3 && seq_state == ST_RUN && $past(proc_halt_n, 2) && $past(pwr_down_n, 2))
    |-> gate_en[0]);

  // R9: no gate runs during the wake-up count
  a_r9_wake_gated: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_WAKE) |-> (gate_en == '0));

  // R10: power-down during wake-up returns to the down state
  a_r10_rewake_down: assert property (@(posedge clk) disable iff (rst)
    ($past(seq_state) == ST_WAKE && cyc >= 3'd3 && !$past(pwr_down_n, 2) && !$past(pwr_down_n, 3))
    |-> (seq_state == ST_DOWN));

endmodule

bind clk_halt_ctrl clkhalt_checker #(.NUM_SYNTH(NUM_SYNTH)) u_chk (
  .clk         (clk_pbus),
  .rst         (rst),
  .proc_halt_n (proc_halt_n),
  .pbus_halt_n (pbus_halt_n),
  .pwr_down_n  (pwr_down_n),
  .xtal_en     (xtal_en),
  .synth_en    (synth_en),
  .gate_en     (gate_en),
  .seq_state   (seq_state)
);

// File: tb/clk_halt_ctrl_bench.sv
`timescale 1ns/1ps
module clk_halt_ctrl_bench;

  localparam int  CLK_PERIOD = 30;
  localparam real PB_HALF    = CLK_PERIOD / 2.0;
  localparam real PR_HALF    = CLK_PERIOD / 4.0;
  localparam real REF_HALF   = 17.0;
  localparam int  WAKE       = 40;
  localparam int  NSYN       = 2;
  localparam real TOL        = 0.01;

  logic clk_pbus = 1'b0;
  logic clk_proc = 1'b1;
  logic clk_ref  = 1'b0;
  logic rst      = 1'b1;
  logic proc_halt_n = 1'b1;
  logic pbus_halt_n = 1'b1;
  logic pwr_down_n  = 1'b1;
  logic proc_clk_gated, pbus_clk_gated, ref_clk_gated, xtal_en;
  logic [NSYN-1:0] synth_en;

  int checks = 0;
  int errors = 0;

  always #(PB_HALF)  clk_pbus = ~clk_pbus;
  always #(PR_HALF)  clk_proc = ~clk_proc;
  always #(REF_HALF) clk_ref  = ~clk_ref;

  clk_halt_ctrl #(.WAKE_CYCLES(WAKE), .NUM_SYNTH(NSYN)) u_clk_halt_ctrl (
    .clk_pbus, .clk_proc, .clk_ref, .rst,
    .proc_halt_n, .pbus_halt_n, .pwr_down_n,
    .proc_clk_gated, .pbus_clk_gated, .ref_clk_gated, .xtal_en, .synth_en
  );

  // Pulse monitors
  int proc_rises = 0, pbus_rises = 0, ref_rises = 0;
  int proc_pulses = 0, pbus_pulses = 0, proc_bad = 0, pbus_bad = 0;
  realtime proc_rise_t = 0, proc_fall_t = -1, pbus_rise_t = 0, pbus_fall_t = -1;
  realtime proc_first_t = 0, pbus_first_t = 0;
  bit proc_arm = 0, pbus_arm = 0;

  always @(posedge proc_clk_gated) begin
    proc_rises++;
    proc_rise_t = $realtime;
    if (proc_fall_t >= 0 && ($realtime - proc_fall_t) < PR_HALF - TOL) proc_bad++;
    if (proc_arm) begin proc_first_t = $realtime; proc_arm = 0; end
  end
  always @(negedge proc_clk_gated) begin
    proc_pulses++;
    proc_fall_t = $realtime;
    if (($realtime - proc_rise_t) > PR_HALF + TOL || ($realtime - proc_rise_t) < PR_HALF - TOL)
      proc_bad++;
  end
  always @(posedge pbus_clk_gated) begin
    pbus_rises++;
    pbus_rise_t = $realtime;
    if (pbus_fall_t >= 0 && ($realtime - pbus_fall_t) < PB_HALF - TOL) pbus_bad++;
    if (pbus_arm) begin pbus_first_t = $realtime; pbus_arm = 0; end
  end
  always @(negedge pbus_clk_gated) begin
    pbus_pulses++;
    pbus_fall_t = $realtime;
    if (($realtime - pbus_rise_t) > PB_HALF + TOL || ($realtime - pbus_rise_t) < PB_HALF - TOL)
      pbus_bad++;
  end
  always @(posedge ref_clk_gated) ref_rises++;

  task automatic chk(input string tag, input bit ok, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  task automatic window(input int cycles, output int dp, output int db, output int dr);
    int p0 = proc_rises;
    int b0 = pbus_rises;
    int r0 = ref_rises;
    repeat (cycles) @(negedge clk_pbus);
    dp = proc_rises - p0;
    db = pbus_rises - b0;
    dr = ref_rises - r0;
  endtask

  task automatic expect_run(input string tag, input string name, input int d, input bit run, input logic lvl);
    if (run) chk(tag, d > 0, $sformatf("%s rises actual %0d expected >0", name, d));
    else     chk(tag, d == 0 && lvl == 1'b0,
                 $sformatf("%s rises/level actual %0d/%0b expected 0/0", name, d, lvl));
  endtask

  task automatic t_reset();
    int dp, db, dr;
    repeat (4) @(negedge clk_pbus);
    window(10, dp, db, dr);
    #1;
    expect_run("R1", "proc", dp, 1, proc_clk_gated);
    expect_run("R1", "pbus", db, 1, pbus_clk_gated);
    expect_run("R1", "ref", dr, 1, ref_clk_gated);
    chk("R1", xtal_en && synth_en == '1,
        $sformatf("xtal/synth actual %0b/%b expected 1/all ones", xtal_en, synth_en));
  endtask

  task automatic t_row(input logic p, input logic b, input string tag);
    int dp, db, dr;
    @(negedge clk_pbus);
    proc_halt_n = p;
    pbus_halt_n = b;
    repeat (6) @(negedge clk_pbus);
    window(10, dp, db, dr);
    #1;
    expect_run(tag, "proc", dp, p, proc_clk_gated);
    expect_run(tag, "pbus", db, b, pbus_clk_gated);
    expect_run("R5", "ref", dr, 1, ref_clk_gated);
    chk("R5", xtal_en && synth_en == '1,
        $sformatf("xtal/synth actual %0b/%b expected 1/all ones", xtal_en, synth_en));
  endtask

  task automatic t_latency(input bit on_proc);
    realtime t0;
    string nm = on_proc ? "proc" : "pbus";
    @(negedge clk_pbus);
    t0 = $realtime;
    if (on_proc) proc_halt_n = 1'b0; else pbus_halt_n = 1'b0;
    repeat (8) @(negedge clk_pbus);
    begin
      realtime last = on_proc ? proc_rise_t : pbus_rise_t;
      chk("R7", last <= t0 + PB_HALF + CLK_PERIOD + TOL,
          $sformatf("%s last rise actual %0.2f expected <= %0.2f", nm, last, t0 + PB_HALF + CLK_PERIOD));
    end
    @(negedge clk_pbus);
    t0 = $realtime;
    if (on_proc) begin proc_arm = 1; proc_halt_n = 1'b1; end
    else         begin pbus_arm = 1; pbus_halt_n = 1'b1; end
    repeat (8) @(negedge clk_pbus);
    begin
      realtime first = on_proc ? proc_first_t : pbus_first_t;
      chk("R8", first > t0 && first <= t0 + PB_HALF + 2 * CLK_PERIOD + TOL,
          $sformatf("%s first rise actual %0.2f expected in (%0.2f,%0.2f]", nm, first, t0,
                    t0 + PB_HALF + 2 * CLK_PERIOD));
    end
  endtask

  task automatic t_power_cycle();
    realtime t0, t1;
    int dp, db, dr;
    @(negedge clk_pbus);
    t0 = $realtime;
    pwr_down_n = 1'b0;
    repeat (4) @(negedge clk_pbus);
    proc_halt_n = 1'b0;
    pbus_halt_n = 1'b1;
    repeat (4) @(negedge clk_pbus);
    chk("R7", proc_rise_t <= t0 + PB_HALF + CLK_PERIOD + TOL,
        $sformatf("proc last rise at power-down actual %0.2f expected <= %0.2f",
                  proc_rise_t, t0 + PB_HALF + CLK_PERIOD));
    window(10, dp, db, dr);
    #1;
    expect_run("R2", "proc", dp, 0, proc_clk_gated);
    expect_run("R2", "pbus", db, 0, pbus_clk_gated);
    chk("R2", dr == 0, $sformatf("ref rises actual %0d expected 0", dr));
    chk("R2", !xtal_en && synth_en == '0,
        $sformatf("xtal/synth actual %0b/%b expected 0/all zeros", xtal_en, synth_en));
    proc_halt_n = 1'b1;
    @(negedge clk_pbus);
    t1 = $realtime;
    proc_arm = 1;
    pbus_arm = 1;
    pwr_down_n = 1'b1;
    window(5, dp, db, dr);
    chk("R9", xtal_en && synth_en == '1 && dp == 0 && db == 0,
        $sformatf("wake xtal/synth/proc/pbus actual %0b/%b/%0d/%0d expected 1/all ones/0/0",
                  xtal_en, synth_en, dp, db));
    repeat (WAKE + 6) @(negedge clk_pbus);
    chk("R9", proc_first_t >= t1 + WAKE * CLK_PERIOD && proc_first_t <= t1 + (WAKE + 5) * CLK_PERIOD,
        $sformatf("proc first rise actual %0.2f expected in [%0.2f,%0.2f]", proc_first_t,
                  t1 + WAKE * CLK_PERIOD, t1 + (WAKE + 5) * CLK_PERIOD));
    chk("R9", pbus_first_t >= t1 + WAKE * CLK_PERIOD && pbus_first_t <= t1 + (WAKE + 5) * CLK_PERIOD,
        $sformatf("pbus first rise actual %0.2f expected in [%0.2f,%0.2f]", pbus_first_t,
                  t1 + WAKE * CLK_PERIOD, t1 + (WAKE + 5) * CLK_PERIOD));
  endtask

  task automatic t_rewake();
    int dp, db, dr;
    @(negedge clk_pbus);
    pwr_down_n = 1'b0;
    repeat (10) @(negedge clk_pbus);
    pwr_down_n = 1'b1;
    repeat (WAKE / 2) @(negedge clk_pbus);
    pwr_down_n = 1'b0;
    window(WAKE + 10, dp, db, dr);
    #1;
    chk("R10", dp == 0 && db == 0,
        $sformatf("proc/pbus rises actual %0d/%0d expected 0/0", dp, db));
    chk("R10", !xtal_en && synth_en == '0,
        $sformatf("xtal/synth actual %0b/%b expected 0/all zeros", xtal_en, synth_en));
    pwr_down_n = 1'b1;
    window(WAKE + 10, dp, db, dr);
    chk("R10", dp > 0 && db > 0,
        $sformatf("restart proc/pbus rises actual %0d/%0d expected >0/>0", dp, db));
  endtask

  bit done = 0;

  initial begin
    repeat (5) @(negedge clk_pbus);
    rst = 1'b0;
    t_reset();
    t_row(1'b0, 1'b1, "R3");
    t_row(1'b1, 1'b0, "R4");
    t_row(1'b0, 1'b0, "R5");
    t_row(1'b1, 1'b1, "R5");
    t_latency(1'b1);
    t_latency(1'b0);
    t_power_cycle();
    t_rewake();
    repeat (4) @(negedge clk_pbus);
    chk("R6", proc_bad == 0 && proc_pulses > 0,
        $sformatf("proc bad pulses actual %0d of %0d expected 0", proc_bad, proc_pulses));
    chk("R6", pbus_bad == 0 && pbus_pulses > 0,
        $sformatf("pbus bad pulses actual %0d of %0d expected 0", pbus_bad, pbus_pulses));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_pbus);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still going expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule